// File: doc/BRIEF.md
# Tagged FIFO Storage Cell

This block is a single first-in first-out cell inside a shared storage unit that several hardware threads use to pass data and to synchronise with each other. An address decoder outside the block turns each bus access into a single-cycle request. The request carries a view code, a read/write strobe, a 64-bit write value and the requester's ID. The view code selects how the access treats the cell. It can read or patch the stored words directly. It can read or rewrite a packed status word. It can push or pop with empty/full flow control, and that flow control either stalls the requester or lets the access go through.

The cell answers every request one cycle later. The answer carries read data and a flag saying the requester must wait. Each waiting requester is recorded in a bitmask. The next empty/full access that completes releases all of them together with a one-cycle wake pulse, and the wake mask shows which requesters were waiting. The logic that actually stalls and retries a requester lives outside the block.

Top module: `tagged_fifo_cell`

## Requirements
- R1: After reset the status word reads empty=1, full=0, T=0, FIFO flag=1, entry count 0 and depth code log2(DEPTH). The default value is 0x0000_0000_3002_0001. No requester is waiting after reset.
- R2: View codes: 0 raw, 1 status, 2 waiting queue, 3 non-waiting queue, 4 waiting semaphore, 5 non-waiting semaphore. A status read (view 1) returns a packed word: empty at bit 0, full at bit 1, T at bit 16, FIFO flag (always 1) at bit 17, entry count from bit 18, depth code from bit 28, and all other bits zero.
- R3: A status write loads T from bit 16, empty from bit 0 and full from bit 1 of the write value. If the new empty bit is 1, the entry count becomes 0.
- R4: A queue write that does not wait clears empty. If the count is below DEPTH it stores the value at the tail and increments the count. A queue write made at count DEPTH is dropped. Full is set whenever such a write leaves the count at DEPTH.
- R5: A queue read that does not wait clears full. If the count is nonzero it returns the oldest entry, in push order, and removes it. Otherwise it returns 0. Empty is set whenever such a read leaves the count at 0.
- R6: A waiting queue read (view 2) made while empty is set, and a waiting queue write made while full is set, answers with the wait flag and data 0. It moves no entry and records the requester's ID in the waiting mask. Before this check, a read still clears full and a write still clears empty.
- R7: A queue access that does not wait, made while the waiting mask is nonzero, raises the wake pulse for one cycle with that mask on the wake mask output. It also clears the waiting mask.
- R8: A raw read (view 0) returns the oldest entry without removing it. A raw write replaces the most recently pushed entry when the count is nonzero and has no effect when the count is 0.
- R9: Semaphore views (4 and 5) read as 0, never ask the requester to wait, and on write change nothing.
- R10: View codes 6 and 7 read as all ones and on write change nothing.
- R11: Each accepted request produces a response exactly one cycle later. A write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_view | input | 3 | View code of the request |
| acc_id | input | ID_W (2) | Requester ID |
| acc_wdata | input | DATA_W (64) | Write value |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_blocked | output | 1 | Requester must wait |
| rsp_rdata | output | DATA_W (64) | Read data of the response |
| wake_valid | output | 1 | One-cycle release pulse |
| wake_mask | output | 2**ID_W (4) | Requesters released by the pulse |

## Verification
A completed queue access can release waiting requesters and move an entry in the same cycle. The bench provokes this in two ways. First, two requesters wait on an empty cell and a third then pushes a value. Second, a requester waits on a full cell and another then pops from it. In each case the wake mask is sampled together with the response and compared against the IDs that waited. A status read that follows confirms that the data movement still took place, with the right count and flags.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

   typedef enum logic [2:0] {
      VW_RAW     = 3'd0,
      VW_TAG     = 3'd1,
      VW_QWAIT   = 3'd2,
      VW_QTRY    = 3'd3,
      VW_SEMWAIT = 3'd4,
      VW_SEMTRY  = 3'd5
   } view_e;

   localparam int TAG_E_BIT   = 0;
   localparam int TAG_F_BIT   = 1;
   localparam int TAG_T_BIT   = 16;
   localparam int TAG_Q_BIT   = 17;
   localparam int TAG_CNT_LSB = 18;
   localparam int TAG_DEP_LSB = 28;
   localparam int TAG_DEP_W   = 4;

endpackage

// File: rtl/tfc_ring.sv
module tfc_ring #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (wr_en && wr_idx == PW'(i))
            slot_q[i] <= wr_data;
      end
   end

   assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/tfc_waitset.sv
module tfc_waitset #(
   parameter int ID_W  = 2,
   localparam int NREQ = 2 ** ID_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            park_en,
   input  logic [ID_W-1:0] park_id,
   input  logic            release_en,
   output logic            wake_valid,
   output logic [NREQ-1:0] wake_mask
);

   logic [NREQ-1:0] held_q;

   for (genvar i = 0; i < NREQ; i++) begin : g_held
      always_ff @(posedge clk) begin
         if (!rst_n)
            held_q[i] <= 1'b0;
         else if (release_en)
            held_q[i] <= 1'b0;
         else if (park_en && park_id == ID_W'(i))
            held_q[i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wake_valid <= 1'b0;
         wake_mask  <= '0;
      end else begin
         wake_valid <= release_en && (held_q != '0);
         wake_mask  <= release_en ? held_q : '0;
      end
   end

   // R7: a pulse always empties the held set and names someone
   assert_wake_clears_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> (held_q == '0 && wake_mask != '0));

   // R6: a parked requester is held on the next cycle
   assert_park_held_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (park_en && !release_en) |=> held_q[$past(park_id)]);

endmodule

// File: rtl/tfc_tagpack.sv
module tfc_tagpack
   import tfc_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int CW       = 4,
   parameter int DEP_CODE = 3
) (
   input  logic              empty,
   input  logic              full,
   input  logic              tbit,
   input  logic [CW-1:0]     count,
   output logic [DATA_W-1:0] word
);

   always_comb begin
      word = '0;
      word[TAG_E_BIT]              = empty;
      word[TAG_F_BIT]              = full;
      word[TAG_T_BIT]              = tbit;
      word[TAG_Q_BIT]              = 1'b1;
      word[TAG_CNT_LSB +: CW]      = count;
      word[TAG_DEP_LSB +: TAG_DEP_W] = TAG_DEP_W'(DEP_CODE);
   end

endmodule

// File: rtl/tagged_fifo_cell.sv
module tagged_fifo_cell
   import tfc_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 8,
   parameter int ID_W   = 2,
   localparam int NREQ  = 2 ** ID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [2:0]        acc_view,
   input  logic [ID_W-1:0]   acc_id,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              rsp_valid,
   output logic              rsp_blocked,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              wake_valid,
   output logic [NREQ-1:0]   wake_mask
);

   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] ONE_CNT  = CW'(1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (CW > TAG_DEP_LSB - TAG_CNT_LSB) begin : g_bad_cnt
      $error("entry count does not fit its status field");
   end
   if (DATA_W < TAG_DEP_LSB + TAG_DEP_W) begin : g_bad_width
      $error("DATA_W too narrow for the status word");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("ID_W must be at least 1");
   end

   logic            e_q, f_q, t_q;
   logic [CW-1:0]   cnt_q;
   logic [PW-1:0]   rptr_q;

   view_e view;
   logic  is_q, waitv, q_rd, q_wr, rd_stall, wr_stall, stall, q_go;
   logic  do_pop, do_push, raw_wr, tag_wr, sem_acc;
   logic  ring_we;
   logic [PW-1:0]     ring_widx;
   logic [DATA_W-1:0] head, tag_word, rdata_c;

   assign view     = view_e'(acc_view);
   assign is_q     = (view == VW_QWAIT) || (view == VW_QTRY);
   assign waitv    = (view == VW_QWAIT);
   assign q_rd     = acc_valid && !acc_write && is_q;
   assign q_wr     = acc_valid && acc_write && is_q;
   assign rd_stall = q_rd && waitv && e_q;
   assign wr_stall = q_wr && waitv && f_q;
   assign stall    = rd_stall || wr_stall;
   assign q_go     = (q_rd || q_wr) && !stall;
   assign do_pop   = q_rd && !stall && (cnt_q != '0);
   assign do_push  = q_wr && !stall && (cnt_q != FULL_CNT);
   assign raw_wr   = acc_valid && acc_write && (view == VW_RAW) && (cnt_q != '0);
   assign tag_wr   = acc_valid && acc_write && (view == VW_TAG);
   assign sem_acc  = acc_valid && ((view == VW_SEMWAIT) || (view == VW_SEMTRY));

   assign ring_we   = do_push || raw_wr;
   assign ring_widx = do_push ? PW'(rptr_q + cnt_q[PW-1:0])
                              : PW'(rptr_q + cnt_q[PW-1:0] - 1'b1);

   tfc_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ring_we),
      .wr_idx  (ring_widx),
      .wr_data (acc_wdata),
      .rd_idx  (rptr_q),
      .rd_data (head)
   );

   tfc_tagpack #(.DATA_W(DATA_W), .CW(CW), .DEP_CODE(PW)) u_pack (
      .empty (e_q),
      .full  (f_q),
      .tbit  (t_q),
      .count (cnt_q),
      .word  (tag_word)
   );

   tfc_waitset #(.ID_W(ID_W)) u_wait (
      .clk        (clk),
      .rst_n      (rst_n),
      .park_en    (stall),
      .park_id    (acc_id),
      .release_en (q_go),
      .wake_valid (wake_valid),
      .wake_mask  (wake_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_q    <= 1'b1;
         f_q    <= 1'b0;
         t_q    <= 1'b0;
         cnt_q  <= '0;
         rptr_q <= '0;
      end else begin
         if (tag_wr) begin
            t_q <= acc_wdata[TAG_T_BIT];
            e_q <= acc_wdata[TAG_E_BIT];
            f_q <= acc_wdata[TAG_F_BIT];
            if (acc_wdata[TAG_E_BIT]) cnt_q <= '0;
         end
         if (q_rd) begin
            f_q <= 1'b0;
            if (do_pop) begin
               rptr_q <= rptr_q + 1'b1;
               cnt_q  <= cnt_q - 1'b1;
            end
            if (!stall && cnt_q <= ONE_CNT) e_q <= 1'b1;
         end
         if (q_wr) begin
            e_q <= 1'b0;
            if (do_push) cnt_q <= cnt_q + 1'b1;
            if (!stall && cnt_q >= FULL_CNT - ONE_CNT) f_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata_c = '0;
      if (!acc_write) begin
         case (view)
            VW_RAW:              rdata_c = head;
            VW_TAG:              rdata_c = tag_word;
            VW_QWAIT, VW_QTRY:   rdata_c = do_pop ? head : '0;
            VW_SEMWAIT, VW_SEMTRY: rdata_c = '0;
            default:             rdata_c = '1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_blocked <= 1'b0;
         rsp_rdata   <= '0;
      end else begin
         rsp_valid   <= acc_valid;
         rsp_blocked <= stall;
         rsp_rdata   <= acc_valid ? rdata_c : '0;
      end
   end

   // R4: count never exceeds the depth
   assert_cnt_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   // R4: the push that fills the cell raises full
   assert_full_set_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (do_push && cnt_q == FULL_CNT - ONE_CNT) |=> (f_q && cnt_q == FULL_CNT));

   // R5: the pop that drains the cell raises empty
   assert_drain_empty_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && cnt_q == ONE_CNT) |=> (e_q && cnt_q == '0));

   // R6: a waiting access moves nothing and is flagged
   assert_stall_holds_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(cnt_q) && $stable(rptr_q) && rsp_blocked));

   // R3: setting empty through the status view drops the count
   assert_ctrl_empty_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (tag_wr && acc_wdata[TAG_E_BIT]) |=> (e_q && cnt_q == '0));

   // R9: semaphore views leave the cell untouched
   assert_sem_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      sem_acc |=> ($stable(cnt_q) && $stable(e_q) && $stable(f_q) &&
                   $stable(rptr_q) && rsp_rdata == '0 && !rsp_blocked));

   // R11: each request is answered on the next cycle
   assert_rsp_follow_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);

endmodule

// File: tb/tagged_fifo_cell_test.sv
module tagged_fifo_cell_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [2:0]  acc_view = '0;
   logic [1:0]  acc_id = '0;
   logic [63:0] acc_wdata = '0;
   logic        rsp_valid, rsp_blocked, wake_valid;
   logic [63:0] rsp_rdata;
   logic [3:0]  wake_mask;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic        g_val, g_blk, g_wv;
   logic [63:0] g_data;
   logic [3:0]  g_wm;

   localparam logic [63:0] BASE = 64'h3002_0000;

   always #2 clk = ~clk;

   tagged_fifo_cell uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_view(acc_view), .acc_id(acc_id), .acc_wdata(acc_wdata),
      .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked), .rsp_rdata(rsp_rdata),
      .wake_valid(wake_valid), .wake_mask(wake_mask)
   );

   function automatic logic [63:0] tagw(bit e, bit f, bit t, int cnt);
      return BASE | 64'(e) | (64'(f) << 1) | (64'(t) << 16) | (64'(cnt) << 18);
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic acc(input logic [2:0] v, input bit wr, input logic [63:0] d,
                      input logic [1:0] id);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_view = v; acc_wdata = d; acc_id = id;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
      g_val = rsp_valid; g_blk = rsp_blocked; g_data = rsp_rdata;
      g_wv = wake_valid; g_wm = wake_mask;
   endtask

   task automatic expect_tag(string req, logic [63:0] exp);
      acc(3'd1, 1'b0, '0, 2'd0);
      chk(req, "status word", g_data, exp);
   endtask

   task automatic t_reset;
      expect_tag("R1", tagw(1, 0, 0, 0));
      chk("R11", "rsp_valid", 64'(g_val), 64'd1);
      chk("R1", "wake idle", 64'(g_wv), 64'd0);
      acc(3'd3, 1'b0, '0, 2'd0);
      chk("R5", "empty try read data", g_data, 64'd0);
      chk("R5", "empty try read no wait", 64'(g_blk), 64'd0);
   endtask

   task automatic t_order;
      for (int i = 0; i < 3; i++) begin
         acc(3'd3, 1'b1, 64'hA0 + 64'(i), 2'd0);
         chk("R11", "write rsp data zero", g_data, 64'd0);
      end
      expect_tag("R2", tagw(0, 0, 0, 3));
      acc(3'd0, 1'b0, '0, 2'd0);
      chk("R8", "raw read head", g_data, 64'hA0);
      expect_tag("R8", tagw(0, 0, 0, 3));
      for (int i = 0; i < 3; i++) begin
         acc(3'd3, 1'b0, '0, 2'd0);
         chk("R5", "pop order", g_data, 64'hA0 + 64'(i));
      end
      expect_tag("R5", tagw(1, 0, 0, 0));
   endtask

   task automatic t_fill;
      for (int i = 0; i < 8; i++) acc(3'd3, 1'b1, 64'hB0 + 64'(i), 2'd0);
      expect_tag("R4", tagw(0, 1, 0, 8));
      acc(3'd3, 1'b1, 64'hDEAD, 2'd0);
      chk("R4", "overfull write no wait", 64'(g_blk), 64'd0);
      expect_tag("R4", tagw(0, 1, 0, 8));
      for (int i = 0; i < 8; i++) begin
         acc(3'd3, 1'b0, '0, 2'd0);
         chk("R4", "wrapped pop order", g_data, 64'hB0 + 64'(i));
      end
      expect_tag("R5", tagw(1, 0, 0, 0));
   endtask

   task automatic t_raw;
      acc(3'd0, 1'b1, 64'h5555, 2'd0);
      expect_tag("R8", tagw(1, 0, 0, 0));
      acc(3'd3, 1'b1, 64'hC1, 2'd0);
      acc(3'd3, 1'b1, 64'hC2, 2'd0);
      acc(3'd0, 1'b1, 64'hC9, 2'd0);
      acc(3'd3, 1'b0, '0, 2'd0);
      chk("R8", "older entry untouched", g_data, 64'hC1);
      acc(3'd3, 1'b0, '0, 2'd0);
      chk("R8", "newest entry replaced", g_data, 64'hC9);
   endtask

   task automatic t_wait_empty;
      acc(3'd2, 1'b0, '0, 2'd2);
      chk("R6", "empty wait flag", 64'(g_blk), 64'd1);
      chk("R6", "empty wait data", g_data, 64'd0);
      acc(3'd2, 1'b0, '0, 2'd1);
      chk("R6", "second wait flag", 64'(g_blk), 64'd1);
      expect_tag("R6", tagw(1, 0, 0, 0));
      acc(3'd3, 1'b1, 64'hD7, 2'd0);
      chk("R7", "push wakes", 64'(g_wv), 64'd1);
      chk("R7", "wake mask", 64'(g_wm), 64'h6);
      chk("R7", "push not flagged", 64'(g_blk), 64'd0);
      expect_tag("R7", tagw(0, 0, 0, 1));
      chk("R7", "pulse single cycle", 64'(g_wv), 64'd0);
      acc(3'd3, 1'b0, '0, 2'd0);
      chk("R7", "pop after wake", g_data, 64'hD7);
      chk("R7", "no second wake", 64'(g_wv), 64'd0);
   endtask

   task automatic t_wait_full;
      for (int i = 0; i < 8; i++) acc(3'd3, 1'b1, 64'hE0 + 64'(i), 2'd0);
      acc(3'd2, 1'b1, 64'hBAD, 2'd3);
      chk("R6", "full wait flag", 64'(g_blk), 64'd1);
      expect_tag("R6", tagw(0, 1, 0, 8));
      acc(3'd2, 1'b0, '0, 2'd0);
      chk("R7", "pop wakes writer", 64'(g_wm), 64'h8);
      chk("R5", "pop head", g_data, 64'hE0);
      expect_tag("R5", tagw(0, 0, 0, 7));
      for (int i = 1; i < 8; i++) begin
         acc(3'd3, 1'b0, '0, 2'd0);
         chk("R6", "stalled write stored nothing", g_data, 64'hE0 + 64'(i));
      end
      expect_tag("R5", tagw(1, 0, 0, 0));
   endtask

   task automatic t_ctrl;
      acc(3'd3, 1'b1, 64'hF1, 2'd0);
      acc(3'd3, 1'b1, 64'hF2, 2'd0);
      acc(3'd1, 1'b1, 64'hFFFF_0000_0001_0002, 2'd0);
      expect_tag("R3", tagw(0, 1, 1, 2));
      acc(3'd1, 1'b1, 64'h1, 2'd0);
      expect_tag("R3", tagw(1, 0, 0, 0));
      acc(3'd1, 1'b1, 64'h3, 2'd0);
      acc(3'd2, 1'b0, '0, 2'd1);
      chk("R6", "wait with both flags", 64'(g_blk), 64'd1);
      expect_tag("R6", tagw(1, 0, 0, 0));
      acc(3'd3, 1'b0, '0, 2'd0);
      chk("R7", "try read releases", 64'(g_wm), 64'h2);
      chk("R5", "empty try read zero", g_data, 64'd0);
   endtask

   task automatic t_sem_bad;
      acc(3'd3, 1'b1, 64'h77, 2'd0);
      acc(3'd4, 1'b0, '0, 2'd0);
      chk("R9", "sem wait read", g_data, 64'd0);
      chk("R9", "sem never waits", 64'(g_blk), 64'd0);
      acc(3'd5, 1'b0, '0, 2'd0);
      chk("R9", "sem try read", g_data, 64'd0);
      acc(3'd4, 1'b1, 64'h99, 2'd0);
      acc(3'd5, 1'b1, 64'h99, 2'd0);
      expect_tag("R9", tagw(0, 0, 0, 1));
      acc(3'd6, 1'b0, '0, 2'd0);
      chk("R10", "view 6 read", g_data, '1);
      acc(3'd7, 1'b1, 64'h1, 2'd0);
      expect_tag("R10", tagw(0, 0, 0, 1));
      acc(3'd0, 1'b0, '0, 2'd0);
      chk("R10", "data kept", g_data, 64'h77);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_order;
      t_fill;
      t_raw;
      t_wait_empty;
      t_wait_full;
      t_ctrl;
      t_sem_bad;
      done = 1'b1;
   end

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
         end
         wait (done);
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule